// File: doc/BRIEF.md
# Converter Power Sequencer

This block is the control-side state machine that powers an analog-to-digital converter up and down on software command. Software issues single-cycle write strobes to turn the converter on, to turn it off, to start or stop conversion on each channel, to start calibration, and to clear the ready flag. It also supplies a two-bit regulator-mode field. The block drives a modelled analog-enable output and waits for the analog side to confirm that it is off before it finishes a shutdown.

After an enable is accepted, a programmable stabilization counter stands in for the converter's startup time. The ready flag rises only when that counter expires, and it raises a level interrupt when the interrupt enable is set. Two conversion channels, regular and injected, each keep a start bit and a stop bit. A channel starts on a software write or on an enabled external trigger. It stops through a stop request that completes when the conversion engine acknowledges it.

An enable request is refused unless the regulator mode is right and no calibration is in progress or has just ended. A disable request is refused while either channel is converting.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, all status outputs (`en_o`, `dis_o`, `rdy_o`, `cal_o`, `start_o`, `stop_o`, `ana_en_o`, `rdy_irq_o`) read 0.
- R2: An enable write is accepted only when `reg_mode_i` equals 2'b01. With any other mode value, `en_o` stays 0.
- R3: An enable write is refused while `cal_o` is 1. It is also refused in each of the 4 cycles after the edge at which `cal_done_i` clears `cal_o`. An enable write held on continuously is accepted at the 5th edge after that clearing edge.
- R4: At the edge where an enable write is accepted, `en_o` and `ana_en_o` rise together. `rdy_o` rises exactly STAB_CYCLES clock edges later.
- R5: `rdy_irq_o` is 1 exactly when `rdy_o` is 1 and `rdy_ie_i` is 1. This holds in the default, unregistered variant.
- R6: A `wr_rdy_clr_i` strobe clears `rdy_o` without changing `en_o`.
- R7: A channel's start bit (bit 0 regular, bit 1 injected) sets on a software start strobe, or on an external trigger whose trigger-enable bit is 1, but only while `rdy_o` is 1. Otherwise the request is ignored.
- R8: A stop strobe while a channel's start bit is 1 sets its stop bit. When `stop_done_i` arrives for that channel, both the stop bit and the start bit clear at the next edge.
- R9: A disable write while any start bit is 1 is ignored: `dis_o` stays 0 and `en_o` stays 1.
- R10: An accepted disable write sets `dis_o` and clears `rdy_o` and `ana_en_o` at the next edge. `en_o` and `dis_o` both stay 1 until `ana_off_i` is seen, and then clear together at the next edge.
- R11: A calibration write sets `cal_o` only while `en_o` is 0. `cal_done_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_mode_i | input | 2 | Regulator-mode field; 2'b01 permits enabling |
| wr_en_set_i | input | 1 | Strobe: write 1 to the enable bit |
| wr_dis_set_i | input | 1 | Strobe: write 1 to the disable bit |
| wr_cal_set_i | input | 1 | Strobe: write 1 to the calibration bit |
| cal_done_i | input | 1 | Calibration engine finished |
| wr_rdy_clr_i | input | 1 | Strobe: write 1 to clear the ready flag |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| wr_start_i | input | NUM_CONV | Per-channel software start strobes |
| wr_stop_i | input | NUM_CONV | Per-channel software stop strobes |
| ext_trig_i | input | NUM_CONV | Per-channel external trigger events |
| trig_en_i | input | NUM_CONV | Per-channel external trigger enables |
| stop_done_i | input | NUM_CONV | Per-channel stop acknowledge from the conversion engine |
| ana_off_i | input | 1 | Analog side reports it is powered off |
| ana_en_o | output | 1 | Modelled analog power enable |
| en_o | output | 1 | Enable bit read-back |
| dis_o | output | 1 | Disable bit read-back |
| rdy_o | output | 1 | Ready flag |
| cal_o | output | 1 | Calibration bit read-back |
| start_o | output | NUM_CONV | Per-channel start bit read-back |
| stop_o | output | NUM_CONV | Per-channel stop bit read-back |
| rdy_irq_o | output | 1 | Ready interrupt |

## Verification
The bench aims at the calibration lockout edge: it holds an enable write and expects refusal for exactly four cycles, then acceptance on the fifth. An off-by-one counter would accept early or late. It counts the stabilization window edge by edge, which catches a timer that fires one cycle early or late. It tries a disable while a channel is converting, which exposes a design that shuts down under an active conversion. It also checks that `en_o` and `dis_o` stay set until the analog acknowledge, which exposes a design that clears them the moment power is dropped. Start requests are applied with no ready flag, and a trigger is applied with its enable off. A design that lets either through would start a conversion on an unpowered converter.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
   typedef enum logic [1:0] {
      PW_OFF   = 2'd0,
      PW_STAB  = 2'd1,
      PW_READY = 2'd2,
      PW_DRAIN = 2'd3
   } pw_state_e;

   localparam int CH_REGULAR  = 0;
   localparam int CH_INJECTED = 1;
endpackage

// File: rtl/adc_cal_lock.sv
module adc_cal_lock #(
   parameter int LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_set_i,
   input  logic cal_done_i,
   output logic cal_o,
   output logic lock_o
);
   localparam int CW = $clog2(LOCK_CYCLES + 1);

   generate
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 1");
      end
   endgenerate

   logic          cal_q;
   logic [CW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q  <= 1'b0;
         hold_q <= '0;
      end else begin
         if (cal_q && cal_done_i) begin
            cal_q  <= 1'b0;
            hold_q <= CW'(LOCK_CYCLES);
         end else begin
            if (cal_set_i) cal_q <= 1'b1;
            if (hold_q != '0) hold_q <= hold_q - 1'b1;
         end
      end
   end

   assign cal_o  = cal_q;
   assign lock_o = cal_q || (hold_q != '0);

   AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q <= CW'(LOCK_CYCLES)); // R3
   AST_LOCK_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_q) |-> lock_o); // R3
endmodule

// File: rtl/adc_stab_timer.sv
module adc_stab_timer #(
   parameter int STAB_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic done_o
);
   localparam int CW = $clog2(STAB_CYCLES + 1);

   generate
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("STAB_CYCLES must be at least 1");
      end
   endgenerate

   logic          run_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (abort_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i) begin
         run_q <= 1'b1;
         cnt_q <= CW'(STAB_CYCLES - 1);
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = run_q && (cnt_q == '0) && !abort_i;

   AST_STAB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(STAB_CYCLES - 1)); // R4
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !run_q); // R4
endmodule

// File: rtl/adc_conv_chan.sv
module adc_conv_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_i,
   input  logic sw_start_i,
   input  logic ext_trig_i,
   input  logic trig_en_i,
   input  logic sw_stop_i,
   input  logic stop_done_i,
   output logic start_o,
   output logic stop_o
);
   logic start_q, stop_q, go;

   assign go = rdy_i && (sw_start_i || (ext_trig_i && trig_en_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         stop_q  <= 1'b0;
      end else if (stop_q) begin
         if (stop_done_i) begin
            stop_q  <= 1'b0;
            start_q <= 1'b0;
         end
      end else if (start_q) begin
         if (sw_stop_i) stop_q <= 1'b1;
      end else if (go) begin
         start_q <= 1'b1;
      end
   end

   assign start_o = start_q;
   assign stop_o  = stop_q;

   AST_STOP_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |-> start_q); // R8
   AST_START_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_q) |-> $past(rdy_i)); // R7
   AST_STOP_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && stop_done_i) |=> (!stop_q && !start_q)); // R8
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_pwr_pkg::*;
#(
   parameter int         STAB_CYCLES   = 16,
   parameter int         LOCK_CYCLES   = 4,
   parameter int         NUM_CONV      = 2,
   parameter int         MODE_W        = 2,
   parameter logic [1:0] MODE_ON       = 2'b01,
   parameter bit         IRQ_REGISTERED = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MODE_W-1:0]   reg_mode_i,
   input  logic                wr_en_set_i,
   input  logic                wr_dis_set_i,
   input  logic                wr_cal_set_i,
   input  logic                cal_done_i,
   input  logic                wr_rdy_clr_i,
   input  logic                rdy_ie_i,
   input  logic [NUM_CONV-1:0] wr_start_i,
   input  logic [NUM_CONV-1:0] wr_stop_i,
   input  logic [NUM_CONV-1:0] ext_trig_i,
   input  logic [NUM_CONV-1:0] trig_en_i,
   input  logic [NUM_CONV-1:0] stop_done_i,
   input  logic                ana_off_i,
   output logic                ana_en_o,
   output logic                en_o,
   output logic                dis_o,
   output logic                rdy_o,
   output logic                cal_o,
   output logic [NUM_CONV-1:0] start_o,
   output logic [NUM_CONV-1:0] stop_o,
   output logic                rdy_irq_o
);
   generate
      if (NUM_CONV < 1) begin : g_bad_conv
         $error("NUM_CONV must be at least 1");
      end
      if (MODE_W != 2) begin : g_bad_mode
         $error("MODE_W must be 2");
      end
   endgenerate

   pw_state_e state_q, state_d;
   logic      rdy_q;
   logic      lock;
   logic      stab_done;
   logic      en_req, dis_req, idle_conv;

   assign idle_conv = ~|start_o;
   assign en_req    = wr_en_set_i && (reg_mode_i == MODE_ON) && !lock
                      && (state_q == PW_OFF);
   assign dis_req   = wr_dis_set_i && idle_conv
                      && ((state_q == PW_STAB) || (state_q == PW_READY));

   adc_cal_lock #(.LOCK_CYCLES(LOCK_CYCLES)) i_cal_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_set_i  (wr_cal_set_i && (state_q == PW_OFF)),
      .cal_done_i (cal_done_i),
      .cal_o      (cal_o),
      .lock_o     (lock)
   );

   adc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) i_stab (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (en_req),
      .abort_i (dis_req),
      .done_o  (stab_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_OFF:   if (en_req) state_d = PW_STAB;
         PW_STAB:  if (dis_req) state_d = PW_DRAIN;
                   else if (stab_done) state_d = PW_READY;
         PW_READY: if (dis_req) state_d = PW_DRAIN;
         PW_DRAIN: if (ana_off_i) state_d = PW_OFF;
         default:  state_d = PW_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PW_OFF;
         rdy_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (dis_req || wr_rdy_clr_i)                 rdy_q <= 1'b0;
         else if (state_q == PW_STAB && stab_done)    rdy_q <= 1'b1;
      end
   end

   assign en_o     = (state_q != PW_OFF);
   assign dis_o    = (state_q == PW_DRAIN);
   assign ana_en_o = (state_q == PW_STAB) || (state_q == PW_READY);
   assign rdy_o    = rdy_q;

   for (genvar c = 0; c < NUM_CONV; c++) begin : g_chan
      adc_conv_chan i_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .rdy_i       (rdy_q),
         .sw_start_i  (wr_start_i[c]),
         .ext_trig_i  (ext_trig_i[c]),
         .trig_en_i   (trig_en_i[c]),
         .sw_stop_i   (wr_stop_i[c]),
         .stop_done_i (stop_done_i[c]),
         .start_o     (start_o[c]),
         .stop_o      (stop_o[c])
      );
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= rdy_q && rdy_ie_i;
         end
         assign rdy_irq_o = irq_q;
      end else begin : g_irq_comb
         assign rdy_irq_o = rdy_q && rdy_ie_i;
      end
   endgenerate

   AST_EN_MODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> ($past(reg_mode_i) == MODE_ON)); // R2
   AST_EN_NOT_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> !$past(cal_o)); // R3
   AST_RDY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> (ana_en_o && en_o)); // R4
   AST_DIS_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_o) |-> ($past(start_o) == '0)); // R9
   AST_OFF_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dis_o) |-> ($past(ana_off_i) && !en_o)); // R10
   AST_DIS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dis_o |-> (en_o && !ana_en_o && !rdy_o)); // R10
   AST_CAL_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_o) |-> !$past(en_o)); // R11
endmodule

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
   localparam int STAB = 6;
   localparam int NC   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    reg_mode_i = 2'b00;
   logic          wr_en_set_i = 1'b0, wr_dis_set_i = 1'b0, wr_cal_set_i = 1'b0;
   logic          cal_done_i = 1'b0, wr_rdy_clr_i = 1'b0, rdy_ie_i = 1'b0;
   logic [NC-1:0] wr_start_i = '0, wr_stop_i = '0, ext_trig_i = '0;
   logic [NC-1:0] trig_en_i = '0, stop_done_i = '0;
   logic          ana_off_i;
   logic          ana_en_o, en_o, dis_o, rdy_o, cal_o, rdy_irq_o;
   logic [NC-1:0] start_o, stop_o;
   logic [2:0]    ack_sr;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   // analog model: reports off three cycles after power is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_sr <= '0;
      else        ack_sr <= {ack_sr[1:0], ana_en_o};
   end
   assign ana_off_i = ~ack_sr[2] & ~ana_en_o;

   adc_pwr_seq #(.STAB_CYCLES(STAB)) i_adc_pwr_seq (
      .clk(clk), .rst_n(rst_n), .reg_mode_i(reg_mode_i),
      .wr_en_set_i(wr_en_set_i), .wr_dis_set_i(wr_dis_set_i),
      .wr_cal_set_i(wr_cal_set_i), .cal_done_i(cal_done_i),
      .wr_rdy_clr_i(wr_rdy_clr_i), .rdy_ie_i(rdy_ie_i),
      .wr_start_i(wr_start_i), .wr_stop_i(wr_stop_i),
      .ext_trig_i(ext_trig_i), .trig_en_i(trig_en_i),
      .stop_done_i(stop_done_i), .ana_off_i(ana_off_i),
      .ana_en_o(ana_en_o), .en_o(en_o), .dis_o(dis_o), .rdy_o(rdy_o),
      .cal_o(cal_o), .start_o(start_o), .stop_o(stop_o),
      .rdy_irq_o(rdy_irq_o)
   );

   // {mode[1:0], expected en_o}
   localparam logic [2:0] VEC [4] = '{3'b000, 3'b011, 3'b100, 3'b110};

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   task automatic enable_write();
      wr_en_set_i = 1'b1; tick(); wr_en_set_i = 1'b0;
   endtask

   task automatic wait_off();
      for (int i = 0; i < 30 && en_o; i++) tick();
   endtask

   task automatic wait_rdy();
      for (int i = 0; i < 30 && !rdy_o; i++) tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      tick(); tick();
      // R1 reset state
      chk("R1 outputs", {en_o, dis_o, rdy_o, cal_o, start_o, stop_o, ana_en_o, rdy_irq_o}, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 after release", {en_o, dis_o, rdy_o, ana_en_o}, 0);

      // R2 table of regulator modes
      foreach (VEC[k]) begin
         reg_mode_i = VEC[k][2:1];
         enable_write();
         chk("R2 enable by mode", int'(en_o), int'(VEC[k][0]));
         if (en_o) begin
            wait_rdy();
            wr_dis_set_i = 1'b1; tick(); wr_dis_set_i = 1'b0;
            wait_off();
            chk("R10 off after mode vector", int'(en_o), 0);
         end
      end
      reg_mode_i = 2'b01;

      // R11 calibration only while off; R3 lockout
      wr_cal_set_i = 1'b1; tick(); wr_cal_set_i = 1'b0;
      chk("R11 cal set", int'(cal_o), 1);
      enable_write();
      chk("R3 enable refused during cal", int'(en_o), 0);
      cal_done_i = 1'b1; tick(); cal_done_i = 1'b0;
      chk("R11 cal cleared", int'(cal_o), 0);
      wr_en_set_i = 1'b1;
      for (int i = 1; i <= 4; i++) begin
         tick();
         chk("R3 lockout cycle", int'(en_o), 0);
      end
      tick();
      chk("R3 accepted on fifth edge", int'(en_o), 1);
      wr_en_set_i = 1'b0;
      chk("R4 analog on with enable", int'(ana_en_o), 1);

      // R4 stabilization window, R7 start ignored while not ready
      wr_start_i = 2'b01;
      for (int j = 1; j < STAB; j++) begin
         tick();
         wr_start_i = 2'b00;
         chk("R4 ready not yet", int'(rdy_o), 0);
      end
      chk("R7 start ignored before ready", int'(start_o), 0);
      tick();
      chk("R4 ready after window", int'(rdy_o), 1);

      // R11 cal write ignored while on
      wr_cal_set_i = 1'b1; tick(); wr_cal_set_i = 1'b0;
      chk("R11 cal ignored while on", int'(cal_o), 0);

      // R5 interrupt
      chk("R5 irq masked", int'(rdy_irq_o), 0);
      rdy_ie_i = 1'b1; #1;
      chk("R5 irq raised", int'(rdy_irq_o), 1);

      // R7 regular start, R9 disable refused while converting
      wr_start_i = 2'b01; tick(); wr_start_i = 2'b00;
      chk("R7 regular start", int'(start_o), 1);
      wr_dis_set_i = 1'b1; tick(); wr_dis_set_i = 1'b0;
      chk("R9 disable ignored", int'({en_o, dis_o}), 2);

      // R8 stop handshake
      wr_stop_i = 2'b01; tick(); wr_stop_i = 2'b00;
      chk("R8 stop set", int'({stop_o, start_o}), 5);
      tick();
      chk("R8 stop pending", int'({stop_o, start_o}), 5);
      stop_done_i = 2'b01; tick(); stop_done_i = 2'b00;
      chk("R8 stop done clears", int'({stop_o, start_o}), 0);

      // R7 injected trigger gating
      ext_trig_i = 2'b10; tick(); ext_trig_i = 2'b00;
      chk("R7 trigger disabled ignored", int'(start_o), 0);
      trig_en_i = 2'b10;
      ext_trig_i = 2'b10; tick(); ext_trig_i = 2'b00;
      chk("R7 injected trigger start", int'(start_o), 2);
      wr_stop_i = 2'b10; tick(); wr_stop_i = 2'b00;
      stop_done_i = 2'b10; tick(); stop_done_i = 2'b00;
      chk("R8 injected stopped", int'({stop_o, start_o}), 0);
      trig_en_i = 2'b00;

      // R6 write-one-to-clear, then R7 start ignored
      wr_rdy_clr_i = 1'b1; tick(); wr_rdy_clr_i = 1'b0;
      chk("R6 ready cleared", int'({en_o, rdy_o}), 2);
      chk("R5 irq follows ready", int'(rdy_irq_o), 0);
      wr_start_i = 2'b11; tick(); wr_start_i = 2'b00;
      chk("R7 start ignored after clear", int'(start_o), 0);
      rdy_ie_i = 1'b0;

      // R10 disable sequence
      wr_dis_set_i = 1'b1; tick(); wr_dis_set_i = 1'b0;
      chk("R10 disabling state", int'({en_o, dis_o, rdy_o, ana_en_o}), 12);
      tick();
      chk("R10 waits for ack", int'({en_o, dis_o}), 3);
      wait_off();
      chk("R10 both cleared", int'({en_o, dis_o}), 0);

      // R10 disable during stabilization clears at once path
      enable_write();
      tick();
      wr_dis_set_i = 1'b1; tick(); wr_dis_set_i = 1'b0;
      chk("R10 disable in window", int'({dis_o, ana_en_o}), 2);
      wait_off();
      repeat (STAB + 2) tick();
      chk("R10 no late ready", int'({en_o, rdy_o}), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule